// File: doc/BRIEF.md
# Armed Interrupt Controller with Delayed Enable

This block arbitrates interrupts for a small 16-bit accumulator processor. It keeps one pending bit per interrupt source, a mask of armed sources and a single global enable bit. Devices raise and drop their pending bits through per-bit strobes. The processor's instruction sequencer passes every I/O-transfer instruction to the block together with the accumulator value. Four commands are recognised: copy the pending bits into the accumulator, load the arm mask from the accumulator, turn interrupts off at once, and turn them on after a delay.

The block raises an interrupt request while the global enable is on and at least one pending source is also armed. At an instruction boundary the sequencer samples that request and may accept it with an acknowledge pulse. It then stores the program counter at the save address the block supplies and continues at the vector address. Accepting an interrupt turns the global enable off. The delayed enable exists so that the instruction after the enable command, usually the return jump of a handler, completes before a new interrupt can be taken.

Top module: `armed_irq_ctrl`

## Requirements
- R1: `irq_req` is high in the same cycle exactly when the global enable is on and (pending bits AND arm mask) is nonzero. A pending bit whose arm bit is 0 cannot raise the request.
- R2: When `irq_ack` is high while `irq_req` is high, the global enable is off from the next cycle. An `irq_ack` while `irq_req` is low is ignored. `save_addr` is constantly 0, `vec_addr` is constantly 1, and `save_word` equals `pc_in` combinationally.
- R3: While `iot_stb` is high and (`iot_code` AND octal 771) equals octal 101, `acc_out` = `acc_in` OR the pending bits as they are before the clock edge. For every other code, `acc_out` = `acc_in`.
- R4: While `iot_stb` is high and (`iot_code` AND octal 771) equals octal 141, the arm mask takes `acc_in` at the clock edge.
- R5: While `iot_stb` is high and (`iot_code` AND octal 771) equals octal 161, the global enable is off from the next cycle and any running enable countdown is cancelled.
- R6: While `iot_stb` is high and (`iot_code` AND octal 772) equals octal 162, a countdown of 2 is loaded. The countdown is decremented on each cycle with `insn_done` high, including the command's own cycle, and the global enable turns on when it reaches zero. Cycles without `insn_done` do not advance it. `irq_req` can therefore first rise after the `insn_done` of the following instruction.
- R7: A code that matches both the disable (R5) and the enable (R6) patterns, for example octal 163, turns the enable off and starts the countdown.
- R8: After reset the arm mask is all ones, the pending bits equal `RESET_FLAGS` (default 16'h0003: bit 0 is the display-sync source and bit 1 is the printer-ready source), the global enable is off and no countdown runs.
- R9: A `flag_set` bit sets its pending bit and a `flag_clr` bit clears it at the next edge. When both are high for the same bit, the set wins.
- R10: While `iot_stb` is low, `iot_code` has no effect: `acc_out` = `acc_in`, and the arm mask, the enable and the countdown do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_set | input | 16 | Per-source set strobes |
| flag_clr | input | 16 | Per-source clear strobes |
| iot_stb | input | 1 | An I/O-transfer instruction executes this cycle |
| iot_code | input | 9 | Low 9 bits of that instruction |
| acc_in | input | 16 | Accumulator value from the processor |
| insn_done | input | 1 | An instruction completes this cycle |
| irq_ack | input | 1 | The sequencer takes the interrupt at this boundary |
| pc_in | input | 13 | Current program counter |
| acc_out | output | 16 | Accumulator value back to the processor |
| irq_req | output | 1 | Interrupt request |
| save_addr | output | 13 | Address at which the PC is saved |
| vec_addr | output | 13 | Address at which execution continues |
| save_word | output | 13 | PC value to be stored |

## Verification
A corrupted pending or arm register shows up at the ports as a wrong `irq_req` from the next cycle on, provided the enable is on. It also shows as a wrong `acc_out` on the next read command. A countdown that is one off moves the first rise of `irq_req` by one completed instruction. The bench therefore checks the request after every cycle and not only at the end of a sequence. An enable bit that is wrongly on or off appears as `irq_req` at the first cycle in which an armed source is pending. The sweep keeps such a source pending throughout for that reason.

// File: rtl/armed_irq_pkg.sv
package armed_irq_pkg;

  localparam int CODE_W = 9;

  // Match masks: bit 0 or bit 1 selects the pulse, bits 8..3 the unit.
  localparam logic [CODE_W-1:0] MASK_P0 = 9'o771;
  localparam logic [CODE_W-1:0] MASK_P1 = 9'o772;

  localparam logic [CODE_W-1:0] OP_READ = 9'o101;
  localparam logic [CODE_W-1:0] OP_ARM  = 9'o141;
  localparam logic [CODE_W-1:0] OP_OFF  = 9'o161;
  localparam logic [CODE_W-1:0] OP_ON   = 9'o162;

  typedef struct packed {
    logic rd;
    logic arm_ld;
    logic off;
    logic on;
  } iot_cmd_t;

  function automatic iot_cmd_t decode_iot(input logic stb,
                                          input logic [CODE_W-1:0] code);
    iot_cmd_t c;
    c.rd     = stb && ((code & MASK_P0) == OP_READ);
    c.arm_ld = stb && ((code & MASK_P0) == OP_ARM);
    c.off    = stb && ((code & MASK_P0) == OP_OFF);
    c.on     = stb && ((code & MASK_P1) == OP_ON);
    return c;
  endfunction

endpackage

// File: rtl/irq_iot_decode.sv
module irq_iot_decode
  import armed_irq_pkg::*;
(
  input  logic              stb,
  input  logic [CODE_W-1:0] code,
  output iot_cmd_t          cmd
);

  always_comb cmd = decode_iot(stb, code);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int          DW          = 16,
  parameter logic [DW-1:0] RESET_FLAGS = 16'h0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic          arm_ld,
  input  logic [DW-1:0] arm_val,
  output logic [DW-1:0] flags_q,
  output logic [DW-1:0] arm_q,
  output logic [DW-1:0] pending
);

  // Set dominates clear for the same bit.
  function automatic logic [DW-1:0] flag_next(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] s,
                                              input logic [DW-1:0] c);
    return (cur & ~c) | s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= RESET_FLAGS;
      arm_q   <= '1;
    end else begin
      flags_q <= flag_next(flags_q, set_i, clr_i);
      if (arm_ld) arm_q <= arm_val;
    end
  end

  assign pending = flags_q & arm_q;

endmodule

// File: rtl/irq_enable_timer.sv
module irq_enable_timer #(
  parameter int DELAY = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             on_cmd,
  input  logic             off_cmd,
  input  logic             take_i,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_mid;
  logic [CNT_W-1:0] cnt_d;
  logic             en_d;

  always_comb begin
    cnt_mid = cnt_q;
    if (on_cmd)       cnt_mid = CNT_W'(DELAY);
    else if (off_cmd) cnt_mid = '0;
    expire = done_i && (cnt_mid == CNT_W'(1));
    cnt_d  = (done_i && cnt_mid != '0) ? cnt_mid - CNT_W'(1) : cnt_mid;
    en_d   = en_q;
    if (expire)            en_d = 1'b1;
    if (off_cmd || take_i) en_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/armed_irq_ctrl.sv
module armed_irq_ctrl
  import armed_irq_pkg::*;
#(
  parameter int            DW          = 16,
  parameter int            AW          = 13,
  parameter int            DELAY       = 2,
  parameter logic [DW-1:0] RESET_FLAGS = 16'h0003,
  parameter logic [AW-1:0] SAVE_ADDR   = '0,
  parameter logic [AW-1:0] VEC_ADDR    = 13'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     flag_set,
  input  logic [DW-1:0]     flag_clr,
  input  logic              iot_stb,
  input  logic [CODE_W-1:0] iot_code,
  input  logic [DW-1:0]     acc_in,
  input  logic              insn_done,
  input  logic              irq_ack,
  input  logic [AW-1:0]     pc_in,
  output logic [DW-1:0]     acc_out,
  output logic              irq_req,
  output logic [AW-1:0]     save_addr,
  output logic [AW-1:0]     vec_addr,
  output logic [AW-1:0]     save_word
);

  localparam int CNT_W = $clog2(DELAY + 1);

  iot_cmd_t         cmd;
  logic             cmd_rd, cmd_arm, cmd_off, cmd_on;
  logic [DW-1:0]    flags_q, arm_q, pending;
  logic             en_q, expire, taken;
  logic [CNT_W-1:0] cnt_q;

  irq_iot_decode u_dec (
    .stb  (iot_stb),
    .code (iot_code),
    .cmd  (cmd)
  );

  assign cmd_rd  = cmd.rd;
  assign cmd_arm = cmd.arm_ld;
  assign cmd_off = cmd.off;
  assign cmd_on  = cmd.on;

  irq_flag_bank #(.DW(DW), .RESET_FLAGS(RESET_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .arm_ld  (cmd_arm),
    .arm_val (acc_in),
    .flags_q (flags_q),
    .arm_q   (arm_q),
    .pending (pending)
  );

  irq_enable_timer #(.DELAY(DELAY), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (insn_done),
    .on_cmd  (cmd_on),
    .off_cmd (cmd_off),
    .take_i  (taken),
    .en_q    (en_q),
    .cnt_q   (cnt_q),
    .expire  (expire)
  );

  assign irq_req   = en_q && (|pending);
  assign taken     = irq_ack && irq_req;
  assign acc_out   = cmd_rd ? (acc_in | flags_q) : acc_in;
  assign save_addr = SAVE_ADDR;
  assign vec_addr  = VEC_ADDR;
  assign save_word = pc_in;

endmodule

// File: rtl/armed_irq_chk.sv
module armed_irq_chk #(
  parameter int DW    = 16,
  parameter int DELAY = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DW-1:0]    flag_set,
  input logic [DW-1:0]    flag_clr,
  input logic [DW-1:0]    acc_in,
  input logic             insn_done,
  input logic             irq_req,
  input logic [DW-1:0]    flags_q,
  input logic [DW-1:0]    arm_q,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             expire,
  input logic             taken,
  input logic             cmd_arm,
  input logic             cmd_off,
  input logic             cmd_on
);

  assert_no_req_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq_req);

  assert_take_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !en_q);

  assert_arm_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_arm |=> arm_q == $past(acc_in));

  assert_off_cancels_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_off && !cmd_on) |=> (!en_q && cnt_q == '0));

  assert_on_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && insn_done) |=> cnt_q == CNT_W'(DELAY - 1));

  assert_count_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_done && !cmd_on && !cmd_off) |=> $stable(cnt_q));

  assert_enable_from_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> ($past(insn_done) && $past(expire)));

  assert_both_cmds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && cmd_off) |=> !en_q);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_clr & ~flag_set)) |=> ((flags_q & $past(flag_clr & ~flag_set)) == '0));

endmodule

bind armed_irq_ctrl armed_irq_chk #(.DW(DW), .DELAY(DELAY), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_armed_irq_ctrl.sv
module sim_armed_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] flag_set = '0, flag_clr = '0;
  logic        iot_stb = 1'b0;
  logic [8:0]  iot_code = '0;
  logic [15:0] acc_in = '0;
  logic        insn_done = 1'b0;
  logic        irq_ack = 1'b0;
  logic [12:0] pc_in = '0;
  logic [15:0] acc_out;
  logic        irq_req;
  logic [12:0] save_addr, vec_addr, save_word;

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [15:0] flags_m = 16'h0003;
  logic [15:0] arm_m   = 16'hFFFF;
  bit          en_m    = 1'b0;
  int          cnt_m   = 0;

  always #4 clk = ~clk;

  armed_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .flag_clr(flag_clr),
    .iot_stb(iot_stb), .iot_code(iot_code), .acc_in(acc_in),
    .insn_done(insn_done), .irq_ack(irq_ack), .pc_in(pc_in),
    .acc_out(acc_out), .irq_req(irq_req), .save_addr(save_addr),
    .vec_addr(vec_addr), .save_word(save_word)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit req_m();
    return en_m && ((flags_m & arm_m) != 16'h0);
  endfunction

  // Completion of one instruction without any command.
  function automatic void tick_model();
    if (cnt_m > 0) begin
      cnt_m = cnt_m - 1;
      if (cnt_m == 0) en_m = 1'b1;
    end
  endfunction

  task automatic check_req(input string req);
    chk(irq_req == req_m(), req, {31'd0, irq_req}, {31'd0, req_m()});
  endtask

  // One I/O instruction that completes in this cycle; called and left at negedge.
  task automatic iot_chk(input logic [8:0] c, input logic [15:0] a, input string req);
    bit rd, ar, off, on;
    logic [15:0] exp;
    rd  = (c[8:3] == 6'o10) && c[0];
    ar  = (c[8:3] == 6'o14) && c[0];
    off = (c[8:3] == 6'o16) && c[0];
    on  = (c[8:3] == 6'o16) && c[1];
    iot_stb = 1'b1; iot_code = c; acc_in = a; insn_done = 1'b1;
    #1;
    exp = rd ? (a | flags_m) : a;
    chk(acc_out == exp, req, {16'd0, acc_out}, {16'd0, exp});
    @(posedge clk);
    if (ar) arm_m = a;
    if (on) begin
      if (off) en_m = 1'b0;
      cnt_m = 1;
    end else if (off) begin
      en_m = 1'b0; cnt_m = 0;
    end else tick_model();
    @(negedge clk);
    iot_stb = 1'b0; insn_done = 1'b0;
    check_req(req);
  endtask

  task automatic step_chk(input string req);
    insn_done = 1'b1;
    @(posedge clk); tick_model(); @(negedge clk);
    insn_done = 1'b0;
    check_req(req);
  endtask

  task automatic idle_chk(input string req);
    @(posedge clk); @(negedge clk);
    check_req(req);
  endtask

  task automatic strobe(input logic [15:0] s, input logic [15:0] c, input string req);
    flag_set = s; flag_clr = c;
    @(posedge clk);
    flags_m = (flags_m & ~c) | s;
    @(negedge clk);
    flag_set = '0; flag_clr = '0;
    check_req(req);
  endtask

  task automatic ack_chk(input logic [12:0] pc, input string req);
    irq_ack = 1'b1; pc_in = pc;
    #1;
    chk(save_word == pc, req, {19'd0, save_word}, {19'd0, pc});
    chk(save_addr == 13'd0, req, {19'd0, save_addr}, 32'd0);
    chk(vec_addr == 13'd1, req, {19'd0, vec_addr}, 32'd1);
    @(posedge clk);
    if (req_m()) en_m = 1'b0;
    @(negedge clk);
    irq_ack = 1'b0;
    check_req(req);
  endtask

  function automatic string tag_of(input logic [8:0] c);
    if ((c[8:3] == 6'o16) && c[0] && c[1]) return "R7";
    if ((c[8:3] == 6'o16) && c[1]) return "R6";
    if ((c[8:3] == 6'o16) && c[0]) return "R5";
    if ((c[8:3] == 6'o14) && c[0]) return "R4";
    if ((c[8:3] == 6'o10) && c[0]) return "R3";
    return "R1";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    check_req("R8");
    iot_chk(9'o101, 16'h0000, "R8");           // flags read as 0003
    iot_chk(9'o162, 16'h0000, "R8");           // enable command
    step_chk("R8");                             // arm all ones -> request

    // R2: acknowledge
    ack_chk(13'h1ABC, "R2");

    // R9: set wins, then clear
    strobe(16'h0008, 16'h0008, "R9");
    iot_chk(9'o101, 16'h8000, "R9");
    strobe(16'h0000, 16'h000B, "R9");
    iot_chk(9'o101, 16'h0000, "R9");

    // R10: strobe low, commands ignored
    iot_code = 9'o141; acc_in = 16'h0000; #1;
    chk(acc_out == 16'h0000, "R10", {16'd0, acc_out}, 32'd0);
    iot_code = 9'o101; acc_in = 16'h1234; #1;
    chk(acc_out == 16'h1234, "R10", {16'd0, acc_out}, 32'h1234);
    iot_code = 9'o162; idle_chk("R10");
    iot_code = 9'o161; insn_done = 1'b1; @(posedge clk); @(negedge clk); insn_done = 1'b0;
    check_req("R10");
    strobe(16'h0100, 16'h0000, "R10");          // arm still all ones, enable still off
    iot_chk(9'o162, 16'h0000, "R10");
    step_chk("R10");                            // request rises: arm was untouched

    // R1: only armed sources count
    iot_chk(9'o141, 16'h0010, "R1");
    strobe(16'h0020, 16'hFFDF, "R1");
    strobe(16'h0010, 16'h0000, "R1");
    strobe(16'h0000, 16'h0010, "R1");

    // R2: acknowledge while no request is ignored
    ack_chk(13'h0005, "R2");
    iot_chk(9'o141, 16'hFFFF, "R2");

    // R6: idle cycles do not advance the countdown
    iot_chk(9'o161, 16'h0000, "R5");
    iot_chk(9'o162, 16'h0000, "R6");
    for (int i = 0; i < 4; i++) idle_chk("R6");
    step_chk("R6");

    // R5: disable cancels a running countdown
    iot_chk(9'o161, 16'h0000, "R5");
    iot_chk(9'o162, 16'h0000, "R5");
    iot_chk(9'o165, 16'h0000, "R5");
    for (int i = 0; i < 3; i++) step_chk("R5");

    // R7: combined code
    iot_chk(9'o162, 16'h0000, "R7");
    step_chk("R7");
    iot_chk(9'o163, 16'h0000, "R7");
    step_chk("R7");

    // Sweep every code with a pending armed source
    strobe(16'h5A3C, 16'h0000, "R9");
    for (int c = 0; c < 512; c++) begin
      logic [15:0] a;
      a = 16'(c * 97) ^ 16'h3C5A;
      if ((c[8:0] & 9'o771) == 9'o141) a = a | 16'h0004;
      iot_chk(9'(c), a, tag_of(9'(c)));
    end
    step_chk("R6");
    step_chk("R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule